// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Status Flag Byte

This block is the arithmetic core of a small eight-bit datapath. Each cycle it takes the current accumulator value, a second operand from a temporary register, a four-bit operation code and an external carry bit. It produces a result at once, on combinational logic. It also raises a write strobe that tells the surrounding datapath to store that result back into the accumulator. Compare and the reserved code never raise the strobe.

The block keeps a registered status byte. When the step enable is high, a clock edge updates the status byte from the result. It updates only the flag bits that the selected operation is defined to affect, and every other bit keeps its old value. Instruction decoding, the register file and memory traffic all stay outside the block.

The reset input is asynchronous and active low. Inside the block it is released in step with the clock.

Top module: `alu8_core`

## Requirements
- R1: Operation codes 0 to 3 select add, add-with-carry, subtract and subtract-with-borrow. The operations are acc+tmp, acc+tmp+cy_i, acc-tmp and acc-tmp-cy_i, each taken modulo 256. They update sign, zero, half-carry, parity and carry.
- R2: Codes 4, 5 and 6 select bitwise AND, XOR and OR of acc and tmp. They update sign, zero and parity, and they clear both the carry flag and the half-carry flag.
- R3: Code 8 gives acc+1 and code 9 gives acc-1, both modulo 256. They update sign, zero, half-carry and parity, and they leave the carry flag as it was.
- R4: Code 7, compare, shows acc-tmp on result_o and sets every flag as subtract would. acc_we_o stays low.
- R5: Code 10 gives the bitwise inverse of acc and changes no flag.
- R6: The rotate codes shift one bit, and only the carry flag changes.
  - Code 11 rotates left: bit 7 moves into bit 0 and into the carry flag.
  - Code 12 rotates right: bit 0 moves into bit 7 and into the carry flag.
  - Code 13 shifts left through the carry: cy_i enters bit 0 and the old bit 7 becomes the carry flag.
  - Code 14 shifts right through the carry: cy_i enters bit 7 and the old bit 0 becomes the carry flag.
- R7: Whenever an operation updates them, the sign flag equals result bit 7. The zero flag is 1 exactly when the result is 0x00. The parity flag is 1 when the result holds an even number of ones.
- R8: For add-type operations, the carry flag is the carry out of bit 7. For subtract and compare, it is 1 when a borrow occurs.
- R9: The half-carry flag is the carry out of bit 3 of the internal adder. Subtraction runs on that adder as acc + ~tmp + (1 - borrow-in), and the flag is read from that sum. As a result, increment sets the flag when acc[3:0] is 0xF, and decrement sets it when acc[3:0] is not 0.
- R10: The flag byte layout is fixed. Bit 7 is sign, bit 6 zero, bit 4 half-carry, bit 2 parity and bit 0 carry. Bit 1 always reads 1, and bits 5 and 3 always read 0. After reset the byte reads 0x02.
- R11: While en_i is low, acc_we_o stays low and no clock edge changes flags_o. Code 15 is reserved: result_o equals acc_i, acc_we_o stays low and the flags are unchanged.
- R12: result_o and acc_we_o follow the inputs in the same cycle. flags_o takes its new value at the first rising clock edge with en_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Step enable: commit flags and allow write-back |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Current accumulator value |
| tmp_i | input | 8 | Second operand |
| cy_i | input | 1 | Carry or borrow in, also the bit fed in by rotates through carry |
| result_o | output | 8 | Combinational operation result |
| acc_we_o | output | 1 | Accumulator write strobe |
| flags_o | output | 8 | Registered status flag byte |

## Verification
The bench goes after four kinds of corner case.

- **Borrow and half-carry polarity in subtraction.** A design that used the raw adder carry as the borrow, or took the half-carry from a true nibble subtraction, would get carry or bit 4 wrong for every pair where acc[3:0] is less than tmp[3:0]. Borrow-in handling is checked with both values of cy_i.
- **Carry preservation on increment and decrement.** Here, carry must survive from whatever the previous operation left. A design that cleared or recomputed it would differ right after an add that carried.
- **Which bit rotates in.** The four rotates must differ in the bit that enters the result. A wrong choice changes result bit 0 or 7.
- **Hold cases.** A design that wrote back on compare, on the reserved code or with the enable low would raise acc_we_o or move flags_o.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int DW    = 8;
  localparam int HALFW = DW / 2;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_AND  = 4'd4,
    OP_XOR  = 4'd5,
    OP_OR   = 4'd6,
    OP_CMP  = 4'd7,
    OP_INC  = 4'd8,
    OP_DEC  = 4'd9,
    OP_NOT  = 4'd10,
    OP_ROL  = 4'd11,
    OP_ROR  = 4'd12,
    OP_RLC  = 4'd13,
    OP_RRC  = 4'd14,
    OP_RSVD = 4'd15
  } alu_op_e;

  // flag byte bit positions
  localparam int FB_SIGN = 7;
  localparam int FB_ZERO = 6;
  localparam int FB_HALF = 4;
  localparam int FB_PAR  = 2;
  localparam int FB_CY   = 0;

  localparam logic [DW-1:0] FLAG_LIVE  = 8'hD5;
  localparam logic [DW-1:0] FLAG_FIXED = 8'h02;

  // update masks per operation class
  localparam logic [DW-1:0] UPD_ALL    = 8'hD5;
  localparam logic [DW-1:0] UPD_NO_CY  = 8'hD4;
  localparam logic [DW-1:0] UPD_CY     = 8'h01;
  localparam logic [DW-1:0] UPD_NONE   = 8'h00;

  function automatic logic even_parity(input logic [DW-1:0] v);
    return ~(^v);
  endfunction

endpackage

// File: rtl/alu8_rst_sync.sv
module alu8_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/alu8_arith.sv
module alu8_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         inv_b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         half_o,
  output logic         cout_o
);

  localparam int HB = W / 2;

  logic [W-1:0] bx;
  logic [W:0]   chain;

  assign bx = inv_b_i ? ~b_i : b_i;

  // ripple adder; the carry into bit HB is the half carry
  always_comb begin
    chain[0] = cin_i;
    for (int i = 0; i < W; i++) begin
      sum_o[i]   = a_i[i] ^ bx[i] ^ chain[i];
      chain[i+1] = (a_i[i] & bx[i]) | (chain[i] & (a_i[i] ^ bx[i]));
    end
  end

  assign half_o = chain[HB];
  assign cout_o = chain[W];

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
(
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cy_i,
  output logic [DW-1:0] res_o,
  output logic          cy_o
);

  always_comb begin
    res_o = a_i;
    cy_o  = 1'b0;
    unique case (op_i)
      OP_AND: res_o = a_i & b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_OR : res_o = a_i | b_i;
      OP_NOT: res_o = ~a_i;
      OP_ROL: begin res_o = {a_i[DW-2:0], a_i[DW-1]}; cy_o = a_i[DW-1]; end
      OP_ROR: begin res_o = {a_i[0], a_i[DW-1:1]};    cy_o = a_i[0];    end
      OP_RLC: begin res_o = {a_i[DW-2:0], cy_i};      cy_o = a_i[DW-1]; end
      OP_RRC: begin res_o = {cy_i, a_i[DW-1:1]};      cy_o = a_i[0];    end
      default: begin res_o = a_i; cy_o = 1'b0; end
    endcase
  end

endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg
  import alu8_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [DW-1:0] upd_i,
  input  logic [DW-1:0] new_i,
  output logic [DW-1:0] flags_o
);

  logic [DW-1:0] flag_q;
  logic [DW-1:0] flag_d;

  always_comb begin
    flag_d = (new_i & upd_i) | (flag_q & ~upd_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag_q <= FLAG_FIXED;
    else if (en_i) flag_q <= flag_d;
  end

  assign flags_o = (flag_q & FLAG_LIVE) | FLAG_FIXED;

  // R11: idle cycles leave the flag byte alone
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(flags_o));

  // R10: masked-off bits never move on an update
  a_r10_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && upd_i == UPD_NONE) |=> $stable(flags_o));

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] tmp_i,
  input  logic          cy_i,
  output logic [DW-1:0] result_o,
  output logic          acc_we_o,
  output logic [DW-1:0] flags_o
);

  alu_op_e       op;
  logic          rst_s_n;

  logic [DW-1:0] ar_b;
  logic          ar_inv;
  logic          ar_cin;
  logic [DW-1:0] ar_sum;
  logic          ar_half;
  logic          ar_cout;
  logic          is_arith;
  logic          is_subtype;
  logic          writes_acc;

  logic [DW-1:0] lg_res;
  logic          lg_cy;

  logic [DW-1:0] upd_mask;
  logic [DW-1:0] flag_new;
  logic          cy_new;
  logic          half_new;

  assign op = alu_op_e'(op_i);

  alu8_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  // adder operand steering
  always_comb begin
    ar_b       = tmp_i;
    ar_inv     = 1'b0;
    ar_cin     = 1'b0;
    is_arith   = 1'b1;
    is_subtype = 1'b0;
    unique case (op)
      OP_ADD: ;
      OP_ADC: ar_cin = cy_i;
      OP_SUB, OP_CMP: begin ar_inv = 1'b1; ar_cin = 1'b1; is_subtype = 1'b1; end
      OP_SBB: begin ar_inv = 1'b1; ar_cin = ~cy_i; is_subtype = 1'b1; end
      OP_INC: begin ar_b = '0; ar_cin = 1'b1; end
      OP_DEC: begin ar_b = '0; ar_inv = 1'b1; end
      default: is_arith = 1'b0;
    endcase
  end

  alu8_arith #(.W(DW)) u_arith (
    .a_i     (acc_i),
    .b_i     (ar_b),
    .inv_b_i (ar_inv),
    .cin_i   (ar_cin),
    .sum_o   (ar_sum),
    .half_o  (ar_half),
    .cout_o  (ar_cout)
  );

  alu8_logic u_logic (
    .op_i  (op),
    .a_i   (acc_i),
    .b_i   (tmp_i),
    .cy_i  (cy_i),
    .res_o (lg_res),
    .cy_o  (lg_cy)
  );

  // result, write strobe and flag update mask
  always_comb begin
    writes_acc = 1'b1;
    upd_mask   = UPD_ALL;
    unique case (op)
      OP_CMP:  writes_acc = 1'b0;
      OP_INC, OP_DEC: upd_mask = UPD_NO_CY;
      OP_NOT:  upd_mask = UPD_NONE;
      OP_ROL, OP_ROR, OP_RLC, OP_RRC: upd_mask = UPD_CY;
      OP_RSVD: begin writes_acc = 1'b0; upd_mask = UPD_NONE; end
      default: ;
    endcase
    result_o = is_arith ? ar_sum : lg_res;
    cy_new   = is_arith ? (ar_cout ^ is_subtype) : lg_cy;
    half_new = is_arith & ar_half;
  end

  always_comb begin
    flag_new          = FLAG_FIXED;
    flag_new[FB_SIGN] = result_o[DW-1];
    flag_new[FB_ZERO] = (result_o == '0);
    flag_new[FB_HALF] = half_new;
    flag_new[FB_PAR]  = even_parity(result_o);
    flag_new[FB_CY]   = cy_new;
  end

  assign acc_we_o = en_i & writes_acc;

  alu8_flagreg u_flagreg (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .en_i    (en_i),
    .upd_i   (upd_mask),
    .new_i   (flag_new),
    .flags_o (flags_o)
  );

  // R4: compare never requests write-back
  a_r4_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_s_n)
    (op_i == 4'd7) |-> !acc_we_o);

  // R3: increment and decrement keep the carry flag
  a_r3_keep_cy: assert property (@(posedge clk) disable iff (!rst_s_n)
    (en_i && (op_i == 4'd8 || op_i == 4'd9)) |=> flags_o[FB_CY] == $past(flags_o[FB_CY]));

  // R5: complement leaves all flags
  a_r5_not_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    (en_i && op_i == 4'd10) |=> $stable(flags_o));

  // R6: rotates touch only the carry flag
  a_r6_rot_only_cy: assert property (@(posedge clk) disable iff (!rst_s_n)
    (en_i && op_i >= 4'd11 && op_i <= 4'd14) |=> flags_o[DW-1:1] == $past(flags_o[DW-1:1]));

  // R7: zero and parity flags follow the committed result
  a_r7_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    (en_i && op_i <= 4'd9) |=> flags_o[FB_ZERO] == ($past(result_o) == '0));

  a_r7_parity: assert property (@(posedge clk) disable iff (!rst_s_n)
    (en_i && op_i <= 4'd9) |=> flags_o[FB_PAR] == ~(^$past(result_o)));

  // R11: no write strobe without enable
  a_r11_no_we_idle: assert property (@(posedge clk) disable iff (!rst_s_n)
    !en_i |-> !acc_we_o);

endmodule

// File: tb/alu8_core_bench.sv
module alu8_core_bench;

  logic       clk;
  logic       rst_n;
  logic       en_i;
  logic [3:0] op_i;
  logic [7:0] acc_i;
  logic [7:0] tmp_i;
  logic       cy_i;
  logic [7:0] result_o;
  logic       acc_we_o;
  logic [7:0] flags_o;

  int checks;
  int failures;
  logic [7:0] mflags;

  alu8_core u_alu8_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .op_i     (op_i),
    .acc_i    (acc_i),
    .tmp_i    (tmp_i),
    .cy_i     (cy_i),
    .result_o (result_o),
    .acc_we_o (acc_we_o),
    .flags_o  (flags_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    #(8 * 190000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s op=%0d acc=%h tmp=%h cy=%b actual=%h expected=%h",
               tag, op_i, acc_i, tmp_i, cy_i, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1, 4'd2, 4'd3: return "R1 R8 R9";
      4'd4, 4'd5, 4'd6:       return "R2";
      4'd7:                   return "R4";
      4'd8, 4'd9:             return "R3 R9";
      4'd10:                  return "R5";
      4'd15:                  return "R11";
      default:                return "R6";
    endcase
  endfunction

  // reference model built from the requirements
  task automatic model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic c, input logic [7:0] fo,
                       output logic [7:0] r, output logic we, output logic [7:0] fn);
    int s;
    int h;
    logic sub;
    logic [7:0] upd;
    logic cyf;
    logic acf;
    r = a; we = 1'b1; upd = 8'hD5; cyf = 1'b0; acf = 1'b0; sub = 1'b0;
    s = 0; h = 0;
    case (op)
      4'd0: begin s = a + b;     h = (a & 15) + (b & 15); end
      4'd1: begin s = a + b + c; h = (a & 15) + (b & 15) + c; end
      4'd2, 4'd7: begin s = a + (~b & 8'hFF) + 1; h = (a & 15) + (~b & 15) + 1; sub = 1'b1; end
      4'd3: begin s = a + (~b & 8'hFF) + (c ? 0 : 1); h = (a & 15) + (~b & 15) + (c ? 0 : 1); sub = 1'b1; end
      4'd8: begin s = a + 1;   h = (a & 15) + 1;  upd = 8'hD4; end
      4'd9: begin s = a + 255; h = (a & 15) + 15; upd = 8'hD4; end
      default: ;
    endcase
    if (op <= 4'd3 || op == 4'd7 || op == 4'd8 || op == 4'd9) begin
      r   = s[7:0];
      cyf = sub ? ~s[8] : s[8];
      acf = h[4];
    end
    case (op)
      4'd4:  r = a & b;
      4'd5:  r = a ^ b;
      4'd6:  r = a | b;
      4'd10: begin r = ~a; upd = 8'h00; end
      4'd11: begin r = {a[6:0], a[7]}; cyf = a[7]; upd = 8'h01; end
      4'd12: begin r = {a[0], a[7:1]}; cyf = a[0]; upd = 8'h01; end
      4'd13: begin r = {a[6:0], c};    cyf = a[7]; upd = 8'h01; end
      4'd14: begin r = {c, a[7:1]};    cyf = a[0]; upd = 8'h01; end
      4'd15: begin r = a; we = 1'b0; upd = 8'h00; end
      default: ;
    endcase
    if (op == 4'd7) we = 1'b0;
    fn = fo;
    if (upd[7]) fn[7] = r[7];
    if (upd[6]) fn[6] = (r == 8'h00);
    if (upd[4]) fn[4] = acf;
    if (upd[2]) fn[2] = ~(^r);
    if (upd[0]) fn[0] = cyf;
  endtask

  // R12: result and strobe sampled in the drive cycle, flags after the edge
  task automatic step(input logic en, input logic [3:0] op, input logic [7:0] a,
                      input logic [7:0] b, input logic c);
    logic [7:0] er;
    logic       ewe;
    logic [7:0] ef;
    @(negedge clk);
    en_i = en; op_i = op; acc_i = a; tmp_i = b; cy_i = c;
    model(op, a, b, c, mflags, er, ewe, ef);
    if (!en) begin ewe = 1'b0; ef = mflags; end
    #1;
    check({tag_of(op), " R12 result"}, result_o, er);
    check({tag_of(op), en ? " R12 write strobe" : " R11 write strobe"}, {7'd0, acc_we_o}, {7'd0, ewe});
    @(posedge clk);
    #1;
    mflags = ef;
    check({tag_of(op), en ? " R7 R10 flags" : " R11 flags"}, flags_o, ef);
  endtask

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0; en_i = 1'b0; op_i = 4'd0; acc_i = 8'h00; tmp_i = 8'h00; cy_i = 1'b0;
    mflags = 8'h02;
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset flags", flags_o, 8'h02);
    check("R11 reset strobe", {7'd0, acc_we_o}, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R10 flags after reset release", flags_o, 8'h02);

    // directed corner values
    step(1'b1, 4'd0, 8'h3A, 8'hC6, 1'b0);   // zero result with carry and half carry
    check("R10 layout after zero-carry add", flags_o, 8'h57);
    step(1'b1, 4'd8, 8'h7F, 8'h00, 1'b0);   // carry must survive increment
    step(1'b1, 4'd9, 8'h00, 8'h00, 1'b0);
    step(1'b1, 4'd2, 8'h10, 8'h01, 1'b0);   // nibble borrow
    step(1'b1, 4'd7, 8'h05, 8'h05, 1'b1);
    step(1'b1, 4'd10, 8'h55, 8'h00, 1'b0);
    step(1'b1, 4'd15, 8'hA5, 8'h00, 1'b1);

    // binary operations, both carry inputs, spread of operand values
    for (int op = 0; op < 8; op++) begin
      for (int c = 0; c < 2; c++) begin
        for (int ia = 0; ia < 21; ia++) begin
          for (int ib = 0; ib < 25; ib++) begin
            step(1'b1, op[3:0], (ia == 20) ? 8'hFF : 8'(ia * 13),
                 (ib == 24) ? 8'hFF : 8'(ib * 11), c[0]);
          end
        end
      end
    end

    // unary operations, every accumulator value, both carry inputs
    for (int op = 8; op < 16; op++) begin
      for (int c = 0; c < 2; c++) begin
        for (int a = 0; a < 256; a++) begin
          step(1'b1, op[3:0], 8'(a), 8'(a * 7 + 3), c[0]);
        end
      end
    end

    // enable low across all codes
    for (int op = 0; op < 16; op++) begin
      for (int k = 0; k < 8; k++) begin
        step(1'b0, op[3:0], 8'(k * 37), 8'(k * 91 + 5), k[0]);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule